// File: doc/BRIEF.md
# Timer Waveform Output Generator

This block turns the count of a free-running or triggered timer into a single waveform bit. It compares the count against two thresholds: a compare threshold that opens the active window and a top value at which the counter wraps. Three modes are available. Repeating PWM produces one pulse every counter period. One-pulse mode produces a single pulse and then stays inactive. Set-once mode produces a single rising edge and then freezes the level it had when the counter reached the top value.

A polarity input inverts the final output. A restart strobe re-arms the single-shot modes so that they can produce another first pulse. Dropping the enable clears all state. The block does not own the counter, the trigger logic or any register preload. Every input is a plain level sampled on each clock, so there is no valid/ready handshake and no back-pressure.

A configuration whose top value is not strictly greater than the compare threshold has no defined waveform. The block flags it on a dedicated output and holds the internal waveform inactive.

Top module: `wave_gen`

## Requirements
- R1: While reset is asserted, the internal waveform is inactive and the single-shot state is cleared, so `wave_o` equals `pol_i`.
- R2: In PWM mode (`mode_i` = 2'b00), the internal waveform becomes active one clock after a cycle in which `cmp_i` < `cnt_i` < `arr_i`, and it is inactive one clock after a cycle in which `cnt_i` <= `cmp_i`.
- R3: In PWM mode, a cycle with `cnt_i` == `arr_i` makes the internal waveform inactive on the next clock.
- R4: In one-pulse mode (`mode_i` = 2'b01), the first pulse follows the PWM rules of R2 and R3. The cycle in which `cnt_i` == `arr_i` marks the pulse done, and from then on the internal waveform stays inactive.
- R5: In set-once mode (`mode_i` = 2'b10), the waveform follows the PWM rules of R2 until `cnt_i` == `arr_i`. In that cycle the pulse is marked done, and the internal waveform keeps the level it held in that cycle, for that cycle and for every later cycle, whatever the counter does.
- R6: `cfg_err_o` is high combinationally whenever `arr_i` <= `cmp_i`, and low otherwise.
- R7: While enabled and not restarting, a cycle with `arr_i` <= `cmp_i` makes the internal waveform inactive on the next clock and leaves the done state unchanged.
- R8: `wave_o` is the internal waveform XOR `pol_i`, so with `pol_i` = 1 the active level is low.
- R9: A cycle with `en_i` and `restart_i` both high clears the done state and makes the internal waveform inactive on the next clock, so the single-shot modes can pulse again.
- R10: A cycle with `en_i` low clears the done state and makes the internal waveform inactive on the next clock.
- R11: Mode code 2'b11 behaves exactly like PWM mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enable; low clears state and forces the waveform inactive |
| restart_i | input | 1 | Re-arm strobe for the single-shot modes |
| mode_i | input | 2 | 00 PWM, 01 one-pulse, 10 set-once, 11 PWM |
| pol_i | input | 1 | Output polarity; 1 inverts the waveform |
| cnt_i | input | W | Current counter value |
| cmp_i | input | W | Compare threshold |
| arr_i | input | W | Top value of the counter |
| wave_o | output | 1 | Waveform output after polarity |
| cfg_err_o | output | 1 | High when arr_i <= cmp_i |

## Verification
The bench builds the block with a 6-bit width. With that width, full counter periods run in a few dozen clocks, and the thresholds can sit at the extremes of the range: a compare value of zero, a top value of 63, and a top value only one above the compare value, which leaves the active window empty. At this width the bench also runs many periods in every mode within a short run, including mode switches, restarts in the middle of a pulse and enable drops after the pulse is done.

// File: rtl/wg_pkg.sv
package wg_pkg;
  typedef enum logic [1:0] {
    WG_PWM  = 2'b00,
    WG_ONE  = 2'b01,
    WG_HOLD = 2'b10,
    WG_ALT  = 2'b11
  } wg_mode_e;
endpackage

// File: rtl/wg_window.sv
// Threshold comparison stage: window, top-of-count and configuration check.
module wg_window #(
  parameter int W = 16
) (
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] cmp_i,
  input  logic [W-1:0] arr_i,
  output logic         in_win_o,
  output logic         at_top_o,
  output logic         bad_o
);
  always_comb begin
    in_win_o = (cnt_i > cmp_i) && (cnt_i < arr_i);
    at_top_o = (cnt_i == arr_i);
    bad_o    = (arr_i <= cmp_i);
  end
endmodule

// File: rtl/wg_seq.sv
// Level and single-shot state registers.
module wg_seq
  import wg_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  input  logic     restart_i,
  input  wg_mode_e mode_i,
  input  logic     in_win_i,
  input  logic     at_top_i,
  input  logic     bad_i,
  output logic     raw_o,
  output logic     done_o
);
  logic raw_q, raw_d;
  logic done_q, done_d;
  logic single_shot;

  assign single_shot = (mode_i == WG_ONE) || (mode_i == WG_HOLD);

  always_comb begin
    raw_d  = raw_q;
    done_d = done_q;
    if (!en_i || restart_i) begin
      raw_d  = 1'b0;
      done_d = 1'b0;
    end else if (bad_i) begin
      raw_d = 1'b0;
    end else if (done_q && single_shot) begin
      if (mode_i == WG_ONE) raw_d = 1'b0;
    end else if (at_top_i) begin
      if (mode_i != WG_HOLD) raw_d = 1'b0;
      if (single_shot) done_d = 1'b1;
    end else begin
      raw_d = in_win_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      raw_q  <= raw_d;
      done_q <= done_d;
    end
  end

  assign raw_o  = raw_q;
  assign done_o = done_q;
endmodule

// File: rtl/wave_gen.sv
module wave_gen
  import wg_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         restart_i,
  input  logic [1:0]   mode_i,
  input  logic         pol_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] cmp_i,
  input  logic [W-1:0] arr_i,
  output logic         wave_o,
  output logic         cfg_err_o
);
  logic     in_win, at_top, bad;
  logic     raw_q, done_q;
  wg_mode_e mode;

  assign mode = wg_mode_e'(mode_i);

  wg_window #(.W(W)) u_win (
    .cnt_i    (cnt_i),
    .cmp_i    (cmp_i),
    .arr_i    (arr_i),
    .in_win_o (in_win),
    .at_top_o (at_top),
    .bad_o    (bad)
  );

  wg_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .restart_i (restart_i),
    .mode_i    (mode),
    .in_win_i  (in_win),
    .at_top_i  (at_top),
    .bad_i     (bad),
    .raw_o     (raw_q),
    .done_o    (done_q)
  );

  assign cfg_err_o = bad;
  assign wave_o    = raw_q ^ pol_i;
endmodule

// File: rtl/wg_chk.sv
module wg_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic         restart,
  input logic [1:0]   mode,
  input logic [W-1:0] cnt,
  input logic [W-1:0] arr,
  input logic         cfg_err,
  input logic         raw,
  input logic         done
);
  // R10
  en_low_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!raw && !done));
  // R9
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && restart) |=> (!raw && !done));
  // R7
  bad_cfg_inactive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !restart && cfg_err) |=> !raw);
  // R4
  one_pulse_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !restart && !cfg_err && done && mode == 2'b01) |=> !raw);
  // R5
  set_once_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !restart && !cfg_err && done && mode == 2'b10) |=> (raw == $past(raw)));
  // R3
  pwm_top_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !restart && !cfg_err && cnt == arr && (mode == 2'b00 || mode == 2'b11)) |=> !raw);
endmodule

bind wave_gen wg_chk #(.W(W)) u_chk (
  .clk     (clk_i),
  .rst_n   (rst_ni),
  .en      (en_i),
  .restart (restart_i),
  .mode    (mode_i),
  .cnt     (cnt_i),
  .arr     (arr_i),
  .cfg_err (cfg_err_o),
  .raw     (raw_q),
  .done    (done_q)
);

// File: tb/sim_wave_gen.sv
`timescale 1ns/1ps
module sim_wave_gen;
  localparam int W = 6;
  localparam int MAXV = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, restart = 1'b0, pol = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [W-1:0] cnt = '0, cmp = '0, arr = '0;
  logic wave, cfg_err;

  int checks = 0, errors = 0;
  bit finished = 0;
  string tag = "R1";

  // reference state
  bit mraw, mdone;

  always #4 clk = ~clk;

  wave_gen #(.W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .restart_i(restart),
    .mode_i(mode), .pol_i(pol), .cnt_i(cnt), .cmp_i(cmp), .arr_i(arr),
    .wave_o(wave), .cfg_err_o(cfg_err)
  );

  // Behavioural reference: one pulse per period, single-shot bookkeeping.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mraw = 0; mdone = 0;
    end else begin
      int c, k, a, md;
      c = int'(cnt); k = int'(cmp); a = int'(arr); md = int'(mode);
      if (!en || restart) begin
        mraw = 0; mdone = 0;
      end else if (a <= k) begin
        mraw = 0;
      end else if (mdone && (md == 1 || md == 2)) begin
        if (md == 1) mraw = 0;
      end else if (c == a) begin
        if (md != 2) mraw = 0;
        if (md == 1 || md == 2) mdone = 1;
      end else begin
        mraw = (c > k) && (c < a);
      end
    end
  end

  task automatic compare();
    bit exp_w, exp_e;
    exp_w = mraw ^ pol;
    exp_e = (int'(arr) <= int'(cmp));
    checks++;
    if (wave !== exp_w) begin
      errors++;
      $display("FAIL %s wave_o actual=%b expected=%b cnt=%0d t=%0t", tag, wave, exp_w, cnt, $time);
    end
    checks++;
    if (cfg_err !== exp_e) begin
      errors++;
      $display("FAIL R6 cfg_err_o actual=%b expected=%b t=%0t", cfg_err, exp_e, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
    compare();
  endtask

  task automatic setup(input int k, input int a, input int md, input bit p);
    cmp = k[W-1:0]; arr = a[W-1:0]; mode = md[1:0]; pol = p;
  endtask

  task automatic periods(input int n);
    for (int p = 0; p < n; p++)
      for (int c = 0; c <= int'(arr); c++) begin
        cnt = c[W-1:0];
        tick();
      end
  endtask

  task automatic expect_bit(input string t, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", t, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired t=%0t", $time);
      report();
      $finish;
    end
  end

  initial begin
    // R1: reset state, both polarities (R8)
    repeat (3) @(posedge clk);
    #2;
    expect_bit("R1 wave_o in reset pol=0", wave, 1'b0);
    pol = 1'b1;
    #1;
    expect_bit("R1 R8 wave_o in reset pol=1", wave, 1'b1);
    pol = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    tick();

    // R2 R3: repeating PWM
    en = 1'b1;
    tag = "R2/R3 pwm";
    setup(10, 20, 0, 0);
    periods(3);
    // a long pulse at the range edges
    setup(0, MAXV, 0, 0);
    periods(1);
    // empty window: arr = cmp + 1
    setup(30, 31, 0, 0);
    periods(2);

    // R8: polarity inverted
    tag = "R8 pol";
    setup(5, 12, 0, 1);
    periods(2);

    // R11: alias mode code
    tag = "R11 mode11";
    setup(7, 15, 3, 0);
    periods(2);

    // R4: one-pulse
    tag = "R4 one-pulse";
    restart = 1'b1; tick(); restart = 1'b0;
    setup(4, 14, 1, 0);
    periods(3);
    // R9: restart re-arms
    tag = "R9 restart";
    restart = 1'b1; cnt = '0; tick(); restart = 1'b0;
    periods(2);
    // restart in the middle of a pulse
    for (int c = 0; c <= 8; c++) begin cnt = c[W-1:0]; tick(); end
    restart = 1'b1; tick(); restart = 1'b0;
    periods(2);

    // R5: set-once
    tag = "R5 set-once";
    restart = 1'b1; tick(); restart = 1'b0;
    setup(5, 30, 2, 0);
    periods(3);
    setup(5, 30, 2, 1);
    periods(1);
    tag = "R9 restart set-once";
    restart = 1'b1; tick(); restart = 1'b0;
    setup(20, 21, 2, 0);
    periods(2);

    // R10: enable drop clears done
    tag = "R10 enable";
    setup(3, 9, 1, 0);
    restart = 1'b1; tick(); restart = 1'b0;
    periods(2);
    en = 1'b0;
    for (int c = 0; c < 5; c++) begin cnt = c[W-1:0]; tick(); end
    en = 1'b1;
    periods(2);
    en = 1'b0;
    setup(3, 9, 0, 0);
    for (int c = 0; c < 9; c++) begin cnt = c[W-1:0]; tick(); end
    en = 1'b1;

    // R6 R7: invalid configurations
    tag = "R7 bad cfg";
    setup(20, 20, 0, 0);
    periods(1);
    setup(25, 10, 0, 0);
    periods(1);
    setup(MAXV, 0, 2, 1);
    periods(1);
    setup(10, 20, 0, 0);
    for (int c = 0; c < 15; c++) begin cnt = c[W-1:0]; tick(); end
    setup(20, 10, 0, 0);
    tick(); tick();
    tag = "R2 recover";
    setup(2, 8, 0, 0);
    periods(2);

    finished = 1;
    report();
    $finish;
  end
endmodule